// File: doc/BRIEF.md
# Configurable Registered Address Buffer

This block registers the address and command lines of a memory module on the rising clock edge and drives them out one cycle later. A static layout strap chooses between two arrangements. The flat arrangement carries 25 data lanes straight through. The duplicated arrangement carries 14 lanes, and each registered bit appears on two output banks, A and B, so that twice as many loads can be driven. When two blocks share the 14-lane work, a second strap tells each one which half of the wide input bus it serves.

The data lanes have a low-power gate. Whenever both chip-select inputs are high at a clock edge, the data registers keep their contents. The clock-enable, termination and both chip-select lines are registered on their own outputs and are never gated. An active-low reset clears every register at once and overrides the gate.

Top module: `regbuf_top`

## Requirements
- R1: In flat layout (`layout_dup_i`=0) with the gate open, `q_a_o` after a rising edge equals `d_i` sampled at that edge.
- R2: In flat layout, all bits of `q_b_o` are low.
- R3: In duplicated layout (`layout_dup_i`=1), `q_b_o` and `q_a_o[13:0]` both carry the same registered 14 lanes, and `q_a_o[24:14]` are low.
- R4: In duplicated layout, `pair_hi_i`=0 selects input lanes `d_i[13:0]` and `pair_hi_i`=1 selects input lanes `d_i[24:11]`, with lane order kept.
- R5: While `rst_n` is low, every output is low. The clear is asynchronous.
- R6: If `sel_a_i` and `sel_b_i` are both high at a rising edge, `q_a_o` and `q_b_o` keep their previous values.
- R7: If either `sel_a_i` or `sel_b_i` is low at a rising edge, the data outputs load the selected lanes.
- R8: Reset overrides the gate. With both selects high and `rst_n` low, the data outputs are low.
- R9: `cke_q_o`, `odt_q_o`, `sel_a_q_o` and `sel_b_q_o` follow `cke_i`, `odt_i`, `sel_a_i` and `sel_b_i` one cycle later, whatever the gate state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous clear |
| layout_dup_i | input | 1 | Static strap: 0 = 25-lane flat, 1 = 14-lane duplicated |
| pair_hi_i | input | 1 | Static strap: input half used in duplicated layout |
| d_i | input | 25 | Address/command data lanes |
| sel_a_i | input | 1 | First chip-select input |
| sel_b_i | input | 1 | Second chip-select input |
| cke_i | input | 1 | Clock-enable line |
| odt_i | input | 1 | Termination-control line |
| q_a_o | output | 25 | Registered data, bank A |
| q_b_o | output | 14 | Registered data copy, bank B |
| cke_q_o | output | 1 | Registered clock-enable |
| odt_q_o | output | 1 | Registered termination control |
| sel_a_q_o | output | 1 | Registered first chip-select |
| sel_b_q_o | output | 1 | Registered second chip-select |

## Verification
Random data words are applied in each of the three strap settings: flat, duplicated with the low half, and duplicated with the high half. Because the two duplicated halves overlap in lanes 11 to 13, a mismatch shows whether a lane was taken from the wrong half or shifted out of order. The select pairs are drawn so that a gated edge, where both selects are high, sits next to edges where exactly one select is high. This separates a gate that tests AND from one that tests either line alone. Reset is pulsed during a gated stretch to confirm that the clear wins and that the ungated side lines keep following their inputs.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

  typedef enum logic {
    LAYOUT_FLAT = 1'b0,
    LAYOUT_DUP  = 1'b1
  } layout_e;

  typedef struct packed {
    logic cke;
    logic odt;
    logic sel_a;
    logic sel_b;
  } side_t;

endpackage

// File: rtl/regbuf_lane_sel.sv
module regbuf_lane_sel
  import regbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic [WIDE_W-1:0] d_i,
  input  layout_e           layout_i,
  input  logic              pair_hi_i,
  output logic [WIDE_W-1:0] lane_o
);

  localparam int SHIFT = WIDE_W - NARROW_W;
  localparam logic [WIDE_W-1:0] LOW_MASK = {{SHIFT{1'b0}}, {NARROW_W{1'b1}}};

  // Flat layout passes every lane; duplicated layout takes one
  // NARROW_W-wide half of the bus and zero-fills the rest.
  function automatic logic [WIDE_W-1:0] pick_lanes(
    input logic [WIDE_W-1:0] d,
    input layout_e           lay,
    input logic              hi
  );
    logic [WIDE_W-1:0] aligned;
    aligned = hi ? (d >> SHIFT) : d;
    return (lay == LAYOUT_DUP) ? (aligned & LOW_MASK) : d;
  endfunction

  assign lane_o = pick_lanes(d_i, layout_i, pair_hi_i);

endmodule

// File: rtl/regbuf_gated_reg.sv
module regbuf_gated_reg #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o[i] <= 1'b0;
      else if (!hold_i) q_o[i] <= d_i[i];
    end
  end

  // R6: a gated edge leaves the register untouched
  a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(q_o));

  // R7: an open edge loads the presented lanes
  a_r7_open_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> (q_o == $past(d_i)));

endmodule

// File: rtl/regbuf_side_reg.sv
module regbuf_side_reg
  import regbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  side_t side_i,
  output side_t side_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) side_o <= '0;
    else        side_o <= side_i;
  end

  // R9: side lines follow their inputs with no gating
  a_r9_side_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (side_o == $past(side_i)));

endmodule

// File: rtl/regbuf_fanout.sv
module regbuf_fanout
  import regbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic [WIDE_W-1:0]   core_i,
  input  layout_e             layout_i,
  output logic [WIDE_W-1:0]   q_a_o,
  output logic [NARROW_W-1:0] q_b_o
);

  logic dup;
  assign dup = (layout_i == LAYOUT_DUP);

  for (genvar i = 0; i < WIDE_W; i++) begin : g_bank_a
    if (i < NARROW_W) begin : g_shared
      assign q_a_o[i] = core_i[i];
    end else begin : g_flat_only
      assign q_a_o[i] = dup ? 1'b0 : core_i[i];
    end
  end

  for (genvar i = 0; i < NARROW_W; i++) begin : g_bank_b
    assign q_b_o[i] = dup ? core_i[i] : 1'b0;
  end

endmodule

// File: rtl/regbuf_top.sv
module regbuf_top
  import regbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                layout_dup_i,
  input  logic                pair_hi_i,
  input  logic [WIDE_W-1:0]   d_i,
  input  logic                sel_a_i,
  input  logic                sel_b_i,
  input  logic                cke_i,
  input  logic                odt_i,
  output logic [WIDE_W-1:0]   q_a_o,
  output logic [NARROW_W-1:0] q_b_o,
  output logic                cke_q_o,
  output logic                odt_q_o,
  output logic                sel_a_q_o,
  output logic                sel_b_q_o
);

  localparam int EXTRA_W = WIDE_W - NARROW_W;

  layout_e           layout;
  logic              hold_evt;
  logic [WIDE_W-1:0] lane_sel;
  logic [WIDE_W-1:0] core_q;
  side_t             side_d;
  side_t             side_q;

  assign layout   = layout_e'(layout_dup_i);
  assign hold_evt = sel_a_i & sel_b_i;
  assign side_d   = '{cke: cke_i, odt: odt_i, sel_a: sel_a_i, sel_b: sel_b_i};

  regbuf_lane_sel #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_lane_sel (
    .d_i       (d_i),
    .layout_i  (layout),
    .pair_hi_i (pair_hi_i),
    .lane_o    (lane_sel)
  );

  regbuf_gated_reg #(.W(WIDE_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (hold_evt),
    .d_i    (lane_sel),
    .q_o    (core_q)
  );

  regbuf_side_reg u_side (
    .clk    (clk),
    .rst_n  (rst_n),
    .side_i (side_d),
    .side_o (side_q)
  );

  regbuf_fanout #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_fanout (
    .core_i   (core_q),
    .layout_i (layout),
    .q_a_o    (q_a_o),
    .q_b_o    (q_b_o)
  );

  assign cke_q_o   = side_q.cke;
  assign odt_q_o   = side_q.odt;
  assign sel_a_q_o = side_q.sel_a;
  assign sel_b_q_o = side_q.sel_b;

  // R2: bank B is silent in flat layout
  a_r2_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !layout_dup_i |-> (q_b_o == '0));

  // R3: both banks agree in duplicated layout, flat-only lanes low
  a_r3_banks_match: assert property (@(posedge clk) disable iff (!rst_n)
    layout_dup_i |-> ((q_b_o == q_a_o[NARROW_W-1:0]) &&
                      (q_a_o[WIDE_W-1:NARROW_W] == {EXTRA_W{1'b0}})));

  // R5: an edge seen in reset is followed by all-low outputs
  a_r5_reset_clears: assert property (@(posedge clk)
    !rst_n |=> ((q_a_o == '0) && (q_b_o == '0) &&
                ({cke_q_o, odt_q_o, sel_a_q_o, sel_b_q_o} == 4'b0)));

  // R8: reset beats the gate
  a_r8_reset_over_gate: assert property (@(posedge clk)
    (!rst_n && hold_evt) |=> ((q_a_o == '0) && (q_b_o == '0)));

endmodule

// File: tb/regbuf_top_test.sv
module regbuf_top_test;

  localparam int WW = 25;
  localparam int NW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dup = 1'b0;
  logic          hi = 1'b0;
  logic [WW-1:0] d = '0;
  logic          sa = 1'b0, sb = 1'b0, cke = 1'b0, odt = 1'b0;
  logic [WW-1:0] q_a;
  logic [NW-1:0] q_b;
  logic          cke_q, odt_q, sa_q, sb_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [WW-1:0] m_core = '0;
  logic [3:0]    m_side = '0;

  always #4 clk = ~clk;

  regbuf_top uut (
    .clk(clk), .rst_n(rst_n), .layout_dup_i(dup), .pair_hi_i(hi), .d_i(d),
    .sel_a_i(sa), .sel_b_i(sb), .cke_i(cke), .odt_i(odt),
    .q_a_o(q_a), .q_b_o(q_b), .cke_q_o(cke_q), .odt_q_o(odt_q),
    .sel_a_q_o(sa_q), .sel_b_q_o(sb_q)
  );

  // Lanes captured by the register, restated per requirement R4
  function automatic logic [WW-1:0] exp_lanes(logic [WW-1:0] din, logic dp, logic h);
    logic [WW-1:0] r;
    r = '0;
    if (!dp) return din;
    for (int i = 0; i < NW; i++) r[i] = h ? din[i + (WW - NW)] : din[i];
    return r;
  endfunction

  function automatic logic [WW-1:0] exp_a(logic [WW-1:0] c, logic dp);
    logic [WW-1:0] r;
    r = c;
    if (dp) for (int i = NW; i < WW; i++) r[i] = 1'b0;
    return r;
  endfunction

  function automatic logic [NW-1:0] exp_b(logic [WW-1:0] c, logic dp);
    return dp ? c[NW-1:0] : '0;
  endfunction

  task automatic chk(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, model the next rising edge, check at the following falling edge
  task automatic cyc(logic r, logic [WW-1:0] din, logic a, logic b, logic ck, logic od);
    string tg;
    rst_n = r; d = din; sa = a; sb = b; cke = ck; odt = od;
    if (!r) begin
      m_core = '0; m_side = '0;
      tg = (a && b) ? "R8" : "R5";
    end else begin
      if (!(a && b)) m_core = exp_lanes(din, dup, hi);
      m_side = {ck, od, a, b};
      if (a && b)      tg = "R6";
      else if (a || b) tg = "R7";
      else if (dup)    tg = hi ? "R4" : "R3";
      else             tg = "R1";
    end
    @(negedge clk);
    chk(tg, q_a, exp_a(m_core, dup));
    chk(dup ? tg : "R2", {{(WW-NW){1'b0}}, q_b}, {{(WW-NW){1'b0}}, exp_b(m_core, dup)});
    chk(r ? "R9" : "R5", {{(WW-4){1'b0}}, cke_q, odt_q, sa_q, sb_q},
        {{(WW-4){1'b0}}, m_side});
  endtask

  task automatic rand_phase(int n);
    for (int k = 0; k < n; k++) begin
      logic [1:0] s;
      s = 2'($urandom_range(0, 3));
      cyc(1'b1, WW'($urandom()), s[1], s[0], 1'($urandom()), 1'($urandom()));
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R5: outputs low during reset with active inputs
    cyc(1'b0, '1, 1'b0, 1'b1, 1'b1, 1'b1);
    cyc(1'b0, '1, 1'b1, 1'b0, 1'b1, 1'b1);

    // Flat layout: directed, then random
    cyc(1'b1, 25'h1ABCDEF, 1'b0, 1'b0, 1'b1, 1'b0);  // R1
    cyc(1'b1, 25'h0123456, 1'b1, 1'b1, 1'b0, 1'b1);  // R6 hold
    cyc(1'b1, 25'h1555555, 1'b1, 1'b0, 1'b1, 1'b1);  // R7 one select
    cyc(1'b1, 25'h0AAAAAA, 1'b0, 1'b1, 1'b0, 1'b0);  // R7 other select
    rand_phase(200);

    // R8: reset during a gated stretch
    cyc(1'b1, 25'h1FFFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 25'h0F0F0F0, 1'b1, 1'b1, 1'b1, 1'b1);

    // Duplicated, low half (straps change only in reset)
    dup = 1'b1; hi = 1'b0;
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 25'h1FFC000, 1'b0, 1'b0, 1'b0, 1'b0);  // R3 upper lanes ignored
    cyc(1'b1, 25'h0003FFF, 1'b0, 1'b0, 1'b1, 1'b1);
    cyc(1'b1, 25'h0000001, 1'b1, 1'b1, 1'b0, 1'b0);  // R6 hold
    rand_phase(200);

    // Duplicated, high half
    hi = 1'b1;
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 25'h00007FF, 1'b0, 1'b0, 1'b0, 1'b0);  // R4 low lanes ignored
    cyc(1'b1, 25'h1000800, 1'b0, 1'b0, 1'b1, 1'b0);  // R4 lane ends
    cyc(1'b1, 25'h1FFFFFF, 1'b1, 1'b1, 1'b1, 1'b1);  // R6 hold
    rand_phase(200);
    cyc(1'b0, '1, 1'b1, 1'b1, 1'b1, 1'b1);           // R8

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule